// File: doc/BRIEF.md
# Cascaded LED-driver chain sequencer

This block is the host-side controller for a daisy chain of serial-input PWM LED drivers that run in external-clock mode. It produces a shift clock and a data line. Each device in the chain gets one fixed-length 224-bit packet, sent most-significant bit first. The farthest device is written first and the nearest one last. When the last packet is out, the block holds the clock low for a programmable number of system-clock cycles so that every device latches its packet.

After the latch gap, the shift clock runs without a break for one whole display period of `2**GS_BITS` clocks. In the first part of the period the data line is held low, and these clocks only advance the drivers' grayscale counters. In the rest of the period the same clock periods carry the next frame's packets. Each display period therefore clocks the PWM and loads the next frame at the same time. The sequence repeats through the next latch gap for as long as `go` stays high.

Packet contents come from a double-buffered store outside the block. The block presents `rd_bank` and `rd_addr` and reads `rd_data` in the same cycle. The block overwrites four control bits in every packet before sending it. A new buffer selection on `buf_sel` takes effect only at the start of a display period.

Top module: `ledseq_chain`

## Requirements
- R1: While reset is asserted, `sck`, `sdo`, `busy` and `frame_done` are 0 and `rd_addr` equals `N_DEV-1`.
- R2: A frame write sends `N_DEV` packets of 224 bits each, packet bit 223 first. The packets go out in device order `N_DEV-1` down to 0. The packet for device k is `rd_data` as read with `rd_addr = k`.
- R3: In every packet sent, bit 216 (external grayscale clock) is forced to 1, bit 215 (timing reset) to 1, bit 214 (display repeat) to 0 and bit 213 (blank) to 0. All other bits pass through unchanged.
- R4: `sdo` changes only in the cycle in which `sck` is low. New data is set up at the falling edge and holds through the rising edge.
- R5: After the last packet, `sck` stays low. The time from the last rising edge of the write to the next rising edge is exactly `2*HALF + GAP_CYC` system cycles. `GAP_CYC` must be at least `16*HALF`.
- R6: `frame_done` is a one-cycle pulse, issued once at the end of every latch gap.
- R7: If `go` is high at the end of a latch gap, `PWM_CLKS = 2**GS_BITS - 224*N_DEV` clock periods with `sdo` low follow, and the next frame write follows them with no break. The number of rising edges between two `frame_done` pulses is `2**GS_BITS`. The first write after start-up has `224*N_DEV` rising edges.
- R8: While idle, `rd_bank` follows `buf_sel`. At other times `rd_bank` takes `buf_sel` only at the cycle that ends a latch gap. A change of `buf_sel` at any other time has no effect on the data shifted out.
- R9: `busy` rises when `go` is accepted from idle. If `go` is low at the end of a latch gap, the block returns to idle: `busy` falls with `frame_done`, and `sck` and `sdo` stay low.
- R10: While running, the shift clock has a period of `2*HALF` system cycles. Consecutive rising edges inside a write or a PWM run are exactly `2*HALF` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Run request; sampled at idle and at the end of each latch gap |
| buf_sel | input | 1 | Requested frame buffer bank |
| rd_bank | output | 1 | Bank currently being read |
| rd_addr | output | DEV_W | Device index of the next packet to read |
| rd_data | input | 224 | Packet for device `rd_addr` in bank `rd_bank`, valid in the same cycle |
| sck | output | 1 | Shift clock to the chain |
| sdo | output | 1 | Serial data to the chain |
| busy | output | 1 | Sequencer is running |
| frame_done | output | 1 | Pulse at the end of each latch gap |

## Verification
The hardest case to reach from the ports is a buffer-select change that arrives while a display period is already running, either in the PWM-only run or in the middle of the next frame's packets. The write must keep reading the bank captured at the period boundary. The stimulus flips `buf_sel` a fixed time into each PWM run and sets it to a random value again in the middle of each write burst. The two banks hold different random contents, so a wrongly timed bank capture corrupts the bit stream. The random contents also carry random values in the four control positions, so a missing override shows up as well. A second start from idle checks that the bank follows the request while idle and that a single-frame run stops cleanly.

// File: rtl/ledseq_pkg.sv
package ledseq_pkg;

    localparam int PKT_BITS   = 224;
    localparam int POS_EXTGS  = 216;
    localparam int POS_TMRST  = 215;
    localparam int POS_REPEAT = 214;
    localparam int POS_BLANK  = 213;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_GAP,
        ST_PWM
    } seq_state_e;

    // Overwrite the mode bits every driver in the chain needs for clocked PWM.
    function automatic logic [PKT_BITS-1:0] force_ctrl(input logic [PKT_BITS-1:0] raw);
        logic [PKT_BITS-1:0] p;
        p             = raw;
        p[POS_EXTGS]  = 1'b1;
        p[POS_TMRST]  = 1'b1;
        p[POS_REPEAT] = 1'b0;
        p[POS_BLANK]  = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/ledseq_sck_gen.sv
module ledseq_sck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic bit_end
);
    localparam int PH_W = $clog2(2 * HALF);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF - 1);
    localparam logic [PH_W-1:0] HALF_V  = PH_W'(HALF);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            sck;
    } sg_t;

    sg_t q, d;

    always_comb begin
        d = q;
        if (run) begin
            d.ph = (q.ph == PH_LAST) ? '0 : q.ph + PH_W'(1);
        end else begin
            d.ph = '0;
        end
        d.sck = (d.ph >= HALF_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign bit_end = run && (q.ph == PH_LAST);

    // R10: the rising edge falls exactly half way through a bit period
    a_r10_rise_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sck) |-> (q.ph == HALF_V));

    // R10: a finished bit period always restarts the phase
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |=> (q.ph == '0));

endmodule

// File: rtl/ledseq_shifter.sv
module ledseq_shifter
    import ledseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic                clear,
    input  logic [PKT_BITS-1:0] pkt_in,
    output logic                sdo,
    output logic                last_bit
);
    localparam int CNT_W = $clog2(PKT_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PKT_BITS - 1);

    typedef struct packed {
        logic [PKT_BITS-1:0] sh;
        logic [CNT_W-1:0]    cnt;
        logic                sdo;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.sdo = pkt_in[PKT_BITS-1];
            d.sh  = {pkt_in[PKT_BITS-2:0], 1'b0};
            d.cnt = '0;
        end else if (shift) begin
            d.sdo = q.sh[PKT_BITS-1];
            d.sh  = {q.sh[PKT_BITS-2:0], 1'b0};
            d.cnt = q.cnt + CNT_W'(1);
        end else if (clear) begin
            d.sdo = 1'b0;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo      = q.sdo;
    assign last_bit = (q.cnt == CNT_LAST);

    // R2: the bit index never runs past the end of a packet
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_LAST);

    // R4: without a command the data line does not move
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || shift || clear) |=> $stable(q.sdo));

endmodule

// File: rtl/ledseq_chain.sv
module ledseq_chain
    import ledseq_pkg::*;
#(
    parameter  int N_DEV   = 256,
    parameter  int GS_BITS = 16,
    parameter  int HALF    = 2,
    parameter  int GAP_CYC = 72,
    localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                buf_sel,
    output logic                rd_bank,
    output logic [DEV_W-1:0]    rd_addr,
    input  logic [PKT_BITS-1:0] rd_data,
    output logic                sck,
    output logic                sdo,
    output logic                busy,
    output logic                frame_done
);
    localparam int PWM_CLKS = (1 << GS_BITS) - PKT_BITS * N_DEV;
    localparam int GAP_W    = $clog2(GAP_CYC + 1);
    localparam logic [DEV_W-1:0]   DEV_LAST = DEV_W'(N_DEV - 1);
    localparam logic [GS_BITS-1:0] PWM_LAST = GS_BITS'(PWM_CLKS - 1);
    localparam logic [GAP_W-1:0]   GAP_LAST = GAP_W'(GAP_CYC - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [DEV_W-1:0]   dev;
        logic [DEV_W-1:0]   addr;
        logic [GS_BITS-1:0] pwm;
        logic [GAP_W-1:0]   gap;
        logic               bank;
        logic               done;
        logic               busy;
    } seq_t;

    seq_t q, d;

    logic                run;
    logic                bit_end;
    logic                last_bit;
    logic                sh_load;
    logic                sh_shift;
    logic                sh_clear;
    logic                take;
    logic [PKT_BITS-1:0] pkt_fixed;

    assign run       = (q.st == ST_WRITE) || (q.st == ST_PWM);
    assign pkt_fixed = force_ctrl(rd_data);

    ledseq_sck_gen #(
        .HALF (HALF)
    ) u_sck (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sck     (sck),
        .bit_end (bit_end)
    );

    ledseq_shifter u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .shift    (sh_shift),
        .clear    (sh_clear),
        .pkt_in   (pkt_fixed),
        .sdo      (sdo),
        .last_bit (last_bit)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        take     = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.bank = buf_sel;
                if (go) begin
                    d.st   = ST_WRITE;
                    d.busy = 1'b1;
                    take   = 1'b1;
                end
            end
            ST_WRITE: begin
                if (bit_end) begin
                    if (!last_bit) begin
                        sh_shift = 1'b1;
                    end else if (q.dev == '0) begin
                        d.st     = ST_GAP;
                        d.gap    = '0;
                        d.addr   = DEV_LAST;
                        sh_clear = 1'b1;
                    end else begin
                        take = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (q.gap == GAP_LAST) begin
                    d.done = 1'b1;
                    if (go) begin
                        d.st   = ST_PWM;
                        d.pwm  = '0;
                        d.bank = buf_sel;
                    end else begin
                        d.st   = ST_IDLE;
                        d.busy = 1'b0;
                    end
                end else begin
                    d.gap = q.gap + GAP_W'(1);
                end
            end
            ST_PWM: begin
                if (bit_end) begin
                    if (q.pwm == PWM_LAST) begin
                        d.st = ST_WRITE;
                        take = 1'b1;
                    end else begin
                        d.pwm = q.pwm + GS_BITS'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        sh_load = take;
        if (take) begin
            d.dev  = q.addr;
            d.addr = (q.addr == '0) ? '0 : q.addr - DEV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.addr <= DEV_LAST;
        end else begin
            q <= d;
        end
    end

    assign rd_bank    = q.bank;
    assign rd_addr    = q.addr;
    assign busy       = q.busy;
    assign frame_done = q.done;

    // R4: data is stable whenever the shift clock is high
    a_r4_sdo_stable: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(sdo));

    // R5: the latch gap keeps the clock low
    a_r5_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GAP) |-> !sck);

    // R6: frame_done never lasts two cycles
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7: PWM-only clocks carry a low data line
    a_r7_pwm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PWM) |-> !sdo);

    // R8: once running, the bank moves only with frame_done
    a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.st) != ST_IDLE) && !frame_done) |-> $stable(rd_bank));

    // R9: an idle sequencer drives nothing
    a_r9_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && !sdo));

endmodule

// File: tb/sim_ledseq_chain.sv
module sim_ledseq_chain;

    localparam int N      = 3;
    localparam int GS     = 11;
    localparam int H      = 2;
    localparam int GAP    = 40;
    localparam int DW     = 2;
    localparam int PERIOD = 1 << GS;
    localparam int WBITS  = 224 * N;
    localparam int PWMC   = PERIOD - WBITS;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, go, buf_sel;
    logic          rd_bank, sck, sdo, busy, frame_done;
    logic [DW-1:0] rd_addr;
    logic [223:0]  rd_data;
    logic [223:0]  mem [2][N];

    assign rd_data = mem[rd_bank][rd_addr];

    ledseq_chain #(
        .N_DEV   (N),
        .GS_BITS (GS),
        .HALF    (H),
        .GAP_CYC (GAP)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .buf_sel    (buf_sel),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .sck        (sck),
        .sdo        (sdo),
        .busy       (busy),
        .frame_done (frame_done)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [223:0] raw, input int pos);
        logic [223:0] p;
        p      = raw;
        p[216] = 1'b1;
        p[215] = 1'b1;
        p[214] = 1'b0;
        p[213] = 1'b0;
        return p[pos];
    endfunction

    // Stream monitor
    longint cyc = 0, last_rise = 0, total_rises = 0;
    int     cnt = 0, done_n = 0, bursts = 0;
    int     dat_bad = 0, ctl_bad = 0, r4_bad = 0, r6_bad = 0, r7_bad = 0, r10_bad = 0;
    logic   sck_p = 0, sdo_p = 0, busy_p = 0, done_p = 0;
    logic   exp_bank = 0, seg_first = 0, gap_pend = 0, fresh = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (busy && !busy_p) begin
                exp_bank  = buf_sel;
                seg_first = 1;
                cnt       = 0;
                gap_pend  = 0;
                fresh     = 1;
            end
            if (sdo != sdo_p && sck) r4_bad++;
            if (frame_done) begin
                done_n++;
                if (done_p) r6_bad++;
                check(cnt == (seg_first ? WBITS : PERIOD), "R7 clocks between latch gaps",
                      cnt, seg_first ? WBITS : PERIOD);
                seg_first = 0;
                cnt       = 0;
                exp_bank  = buf_sel;
                gap_pend  = 1;
            end
            if (sck && !sck_p) begin
                total_rises++;
                if (gap_pend) begin
                    check(cyc - last_rise == 2 * H + GAP, "R5 latch gap length",
                          cyc - last_rise, 2 * H + GAP);
                    gap_pend = 0;
                end else if (!fresh && (cyc - last_rise != 2 * H)) begin
                    r10_bad++;
                end
                fresh     = 0;
                last_rise = cyc;
                if (!seg_first && cnt < PWMC) begin
                    if (sdo) r7_bad++;
                end else begin
                    int w, dv, pos;
                    w   = seg_first ? cnt : cnt - PWMC;
                    dv  = N - 1 - w / 224;
                    pos = 223 - w % 224;
                    if (sdo !== exp_bit(mem[exp_bank][dv], pos)) begin
                        if (pos inside {[213:216]}) ctl_bad++;
                        else                        dat_bad++;
                    end
                    if (w == WBITS - 1) begin
                        check(dat_bad == 0, "R2,R8 packet order and bank", dat_bad, 0);
                        check(ctl_bad == 0, "R3 forced control bits", ctl_bad, 0);
                        bursts++;
                        dat_bad = 0;
                        ctl_bad = 0;
                    end
                end
                cnt++;
            end
            sck_p  = sck;
            sdo_p  = sdo;
            busy_p = busy;
            done_p = frame_done;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    task automatic wait_done();
        do @(negedge clk); while (!frame_done);
    endtask

    initial begin
        longint r;
        rst_n   = 1'b0;
        go      = 1'b0;
        buf_sel = 1'b0;
        void'($urandom(32'h1ed5));
        for (int b = 0; b < 2; b++)
            for (int dv = 0; dv < N; dv++)
                for (int k = 0; k < 7; k++)
                    mem[b][dv][k*32 +: 32] = $urandom();

        repeat (3) @(negedge clk);
        check(sck == 0, "R1 reset sck", sck, 0);
        check(sdo == 0, "R1 reset sdo", sdo, 0);
        check(busy == 0, "R1 reset busy", busy, 0);
        check(frame_done == 0, "R1 reset frame_done", frame_done, 0);
        check(rd_addr == DW'(N - 1), "R1 reset rd_addr", rd_addr, N - 1);

        @(posedge clk); #2 rst_n = 1'b1;
        repeat (5) @(posedge clk); #2 buf_sel = 1'($urandom() % 2);
        repeat (3) @(posedge clk); #2 go = 1'b1;
        wait_done();
        check(busy == 1, "R9 busy while running", busy, 1);

        for (int k = 0; k < 4; k++) begin
            repeat (200) @(posedge clk); #2 buf_sel = ~buf_sel;
            repeat (5800) @(posedge clk); #2 buf_sel = 1'($urandom() % 2);
            if (k == 3) go = 1'b0;
            wait_done();
        end
        check(busy == 0, "R9 busy falls at final latch", busy, 0);
        r = total_rises;
        repeat (200) @(negedge clk);
        check(total_rises == r, "R9 clock stopped when idle", total_rises - r, 0);
        check(sdo == 0, "R9 data low when idle", sdo, 0);

        // Second start: bank follows request while idle, single-frame run
        @(posedge clk); #2 buf_sel = 1'b1;
        repeat (4) @(posedge clk); #2 go = 1'b1;
        do @(negedge clk); while (!busy);
        @(posedge clk); #2 go = 1'b0;
        repeat (300) @(posedge clk); #2 buf_sel = 1'b0;
        wait_done();
        check(busy == 0, "R9 single frame returns idle", busy, 0);
        repeat (20) @(negedge clk);

        check(r4_bad == 0, "R4 data changes only with clock low", r4_bad, 0);
        check(r6_bad == 0, "R6 frame_done single cycle", r6_bad, 0);
        check(done_n == 6, "R6 frame_done count", done_n, 6);
        check(r7_bad == 0, "R7 data low during PWM clocks", r7_bad, 0);
        check(r10_bad == 0, "R10 shift clock period", r10_bad, 0);
        check(bursts == 6, "R2 completed write bursts", bursts, 6);

        summary();
        $finish;
    end

endmodule